// File: doc/BRIEF.md
# Decimation Rate and Settling Sequencer

This block times the output stage of a decimating sigma-delta converter. It runs on the master clock. The modulator samples at half that rate, so one conversion period lasts twice the oversampling ratio, counted in master clocks. The block issues a one-cycle conversion strobe at the end of every period. The filter datapath elsewhere uses that strobe to produce a result.

When a restart is requested, the block does four things:
- It pulses a filter-restart output.
- It waits a short fixed overhead. This overhead depends on the speed mode and is lengthened when the input buffers are on.
- It starts counting conversion periods.
- It withholds data-ready until the filter has fully settled.

An explicit sync pulse requests a restart. So does any change of the ratio code or the speed mode.

Once data-ready is released, it pulses with every strobe. A settled status tells the consumer whether the current results are fully settled. An unsynchronised input step, signalled by the system, marks the following results as partial until the filter has flushed.

Top module: `decim_seq`

## Requirements
- R1: Outside the overhead phase, `conv_strobe` is high for one cycle in every 64·2^`osr_sel` master clocks, so code 0 gives a ratio of 32 and code 7 gives a ratio of 4096. After reset the period counter starts at once with code 0 stored.
- R2: No conversion strobe occurs during the overhead phase. The first strobe after a restart comes one full period after the overhead ends.
- R3: A `sync_req` sampled high makes `filt_restart` high for the following cycle and restarts the whole sequence.
- R4: Any difference between the present `osr_sel` or `speed_lo` and the values taken at the last restart or reset (code 0, high speed) acts exactly like a sync request.
- R5: The overhead lasts OVH_HS master clocks when `speed_lo` is 0 and OVH_LS when it is 1. It is 8 clocks longer when `buf_en` is high at the restart edge. So the first `data_ready` comes overhead + 68 periods after the restart.
- R6: After a restart, the first 67 strobes carry no `data_ready`. The 68th strobe and every strobe after it carry a one-cycle `data_ready`.
- R7: A sync that arrives while data-ready is still being withheld restarts both the overhead and the 68-period count from zero.
- R8: `settled` rises in the cycle after the first `data_ready`. It is low in the cycle of `filt_restart`.
- R9: An `in_step` pulse drops `settled` for the next 69 strobes that follow the edge where it is sampled, and `settled` returns the cycle after the 69th. A step that coincides with a strobe does not count that strobe.
- R10: During and straight after reset, `filt_restart`, `conv_strobe`, `data_ready` and `settled` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_lo | input | 1 | 1 selects low-speed mode (longer overhead) |
| osr_sel | input | 3 | Oversampling ratio code, ratio = 32·2^code |
| sync_req | input | 1 | Restart request pulse |
| buf_en | input | 1 | Input buffers enabled, adds 8 clocks of overhead |
| in_step | input | 1 | Unsynchronised input step marker |
| filt_restart | output | 1 | One-cycle filter restart pulse |
| conv_strobe | output | 1 | One-cycle end-of-conversion strobe |
| data_ready | output | 1 | One-cycle result-valid pulse, settled filter only |
| settled | output | 1 | Results currently fully settled |

## Verification
Two pairs of functions are made to land in the same cycle.

The first pair is an input step and a conversion strobe. The bench raises `in_step` at the falling edge where a strobe is visible, so the partial-count load and the decrement meet at one clock edge. The check is that exactly 69 further strobes pass with `settled` low.

The second pair is a sync and a released data-ready. The bench asserts `sync_req` in a data-ready cycle and expects the restart to win: `settled` must not rise and `filt_restart` must follow.

Both cases are also judged against the cycle model in the bench on every clock.

// File: rtl/decim_seq.sv
module decim_seq #(
  parameter int OVH_HS    = 10,
  parameter int OVH_LS    = 15,
  parameter int BUF_EXTRA = 8,
  parameter int SETTLE    = 68,
  parameter int PARTIAL   = 69,
  parameter int BASE_LOG  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_lo,
  input  logic [2:0] osr_sel,
  input  logic       sync_req,
  input  logic       buf_en,
  input  logic       in_step,
  output logic       filt_restart,
  output logic       conv_strobe,
  output logic       data_ready,
  output logic       settled
);
  localparam int DIV_W  = BASE_LOG + 7;
  localparam int OVH_MX = ((OVH_HS > OVH_LS) ? OVH_HS : OVH_LS) + BUF_EXTRA;
  localparam int OVH_W  = $clog2(OVH_MX + 1);
  localparam int CNT_W  = $clog2(SETTLE + 1);
  localparam int PART_W = $clog2(PARTIAL + 1);

  logic [2:0]       osr_q;
  logic             spd_q, in_ovh, rel_q;
  logic [OVH_W-1:0] ovh_q, ovh_load;
  logic [DIV_W-1:0] div_q, per_m1;
  logic [DIV_W:0]   per;
  logic [CNT_W-1:0] nconv_q;
  logic [PART_W-1:0] part_q;
  logic             restart;

  assign per      = (DIV_W+1)'(1) << (BASE_LOG + int'(osr_q));
  assign per_m1   = DIV_W'(per - 1'b1);
  assign restart  = sync_req | (osr_sel != osr_q) | (speed_lo != spd_q);
  assign ovh_load = OVH_W'((speed_lo ? OVH_LS : OVH_HS) + (buf_en ? BUF_EXTRA : 0));

  assign conv_strobe = !in_ovh && (div_q == per_m1);
  assign data_ready  = conv_strobe && (nconv_q == CNT_W'(SETTLE - 1));
  assign settled     = rel_q && (part_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_restart <= 1'b0;
      osr_q   <= '0;
      spd_q   <= 1'b0;
      in_ovh  <= 1'b0;
      ovh_q   <= '0;
      div_q   <= '0;
      nconv_q <= '0;
      rel_q   <= 1'b0;
      part_q  <= '0;
    end else begin
      filt_restart <= restart;
      if (restart) begin
        osr_q   <= osr_sel;
        spd_q   <= speed_lo;
        in_ovh  <= 1'b1;
        ovh_q   <= ovh_load;
        div_q   <= '0;
        nconv_q <= '0;
        rel_q   <= 1'b0;
        part_q  <= '0;
      end else begin
        if (in_ovh) begin
          if (ovh_q == OVH_W'(1)) in_ovh <= 1'b0;
          else ovh_q <= ovh_q - 1'b1;
        end else begin
          div_q <= conv_strobe ? '0 : div_q + 1'b1;
        end
        if (conv_strobe && nconv_q != CNT_W'(SETTLE - 1)) nconv_q <= nconv_q + 1'b1;
        if (data_ready) rel_q <= 1'b1;
        if (in_step) part_q <= PART_W'(PARTIAL);
        else if (conv_strobe && part_q != '0) part_q <= part_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/decim_seq_checks.sv
module decim_seq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] osr_sel,
  input logic       speed_lo,
  input logic       in_step,
  input logic       filt_restart,
  input logic       conv_strobe,
  input logic       data_ready,
  input logic       settled
);
  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_strobe |=> !conv_strobe);

  assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filt_restart |-> (!conv_strobe && !data_ready && !settled));

  assert_mode_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && (osr_sel != $past(osr_sel) || speed_lo != $past(speed_lo))) |=> filt_restart);

  assert_settle_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(conv_strobe));

  assert_settle_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(settled) |-> ($past(in_step) || filt_restart));
endmodule

bind decim_seq decim_seq_checks i_checks (
  .clk(clk), .rst_n(rst_n), .osr_sel(osr_sel), .speed_lo(speed_lo), .in_step(in_step),
  .filt_restart(filt_restart), .conv_strobe(conv_strobe), .data_ready(data_ready),
  .settled(settled)
);

// File: tb/test_decim_seq.sv
module test_decim_seq;
  localparam int CLK_PERIOD = 10;
  localparam int OVH_HS = 10, OVH_LS = 15, BUF_X = 8, NSET = 68, NPART = 69;

  logic clk = 1'b0, rst_n = 1'b0, speed_lo = 1'b0, sync_req = 1'b0, buf_en = 1'b0, in_step = 1'b0;
  logic [2:0] osr_sel = 3'd0;
  logic filt_restart, conv_strobe, data_ready, settled;

  decim_seq #(.OVH_HS(OVH_HS), .OVH_LS(OVH_LS), .BUF_EXTRA(BUF_X), .SETTLE(NSET),
              .PARTIAL(NPART), .BASE_LOG(6)) i_decim_seq (
    .clk(clk), .rst_n(rst_n), .speed_lo(speed_lo), .osr_sel(osr_sel), .sync_req(sync_req),
    .buf_en(buf_en), .in_step(in_step), .filt_restart(filt_restart), .conv_strobe(conv_strobe),
    .data_ready(data_ready), .settled(settled));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cycles = 0;
  bit started = 0;
  string phase = "R10";

  int t = 0, n_ovh = 0, m_osr = 0, m_part = 0;
  bit m_spd = 0, m_rel = 0, m_fr = 0;

  function automatic int per();
    return 64 << m_osr;
  endfunction
  function automatic bit exp_strobe();
    int u = t - n_ovh + 1;
    return (t >= n_ovh) && (u >= per()) && (u % per() == 0);
  endfunction
  function automatic bit exp_dr();
    return exp_strobe() && ((t - n_ovh + 1) / per() >= NSET);
  endfunction

  always @(posedge clk) begin
    bit s, d;
    started = 1;
    s = exp_strobe();
    d = exp_dr();
    if (!rst_n) begin
      t = 0; n_ovh = 0; m_osr = 0; m_spd = 0; m_rel = 0; m_part = 0; m_fr = 0;
    end else if (sync_req || int'(osr_sel) != m_osr || speed_lo != m_spd) begin
      m_fr = 1; t = 0; m_osr = int'(osr_sel); m_spd = speed_lo;
      n_ovh = (speed_lo ? OVH_LS : OVH_HS) + (buf_en ? BUF_X : 0);
      m_rel = 0; m_part = 0;
    end else begin
      m_fr = 0;
      if (d) m_rel = 1;
      if (in_step) m_part = NPART;
      else if (s && m_part > 0) m_part--;
      t++;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) cycle %0d: actual %b expected %b", req, phase, cycles, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual %0d expected %0d", req, phase, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      chk((t < n_ovh) ? "R2" : "R1", conv_strobe, exp_strobe());
      chk("R6", data_ready, exp_dr());
      chk("R3", filt_restart, m_fr);
      chk(m_part > 0 ? "R9" : "R8", settled, m_rel && m_part == 0);
    end
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic restart_timed(input string req, input int osr, input bit spd, input bit buf_on,
                               input bit do_sync);
    int n = 0, expn;
    phase = req;
    osr_sel = 3'(osr); speed_lo = spd; buf_en = buf_on; sync_req = do_sync;
    expn = (spd ? OVH_LS : OVH_HS) + (buf_on ? BUF_X : 0) + NSET * (64 << osr);
    do begin
      @(negedge clk);
      sync_req = 1'b0;
      n++;
    end while (!data_ready && n < 20000);
    chk_int(req, n, expn);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", filt_restart | conv_strobe | data_ready | settled, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", filt_restart | conv_strobe | data_ready | settled, 1'b0);
    phase = "R6";
    while (!data_ready) @(negedge clk);
    @(negedge clk);
    chk("R8", settled, 1'b1);

    restart_timed("R3", 0, 1'b0, 1'b0, 1'b1);
    restart_timed("R5", 1, 1'b1, 1'b1, 1'b0);
    restart_timed("R4", 1, 1'b0, 1'b0, 1'b0);

    phase = "R7";
    sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
    repeat (500) @(negedge clk);
    restart_timed("R7", 1, 1'b0, 1'b0, 1'b1);

    begin
      int strobes = 0;
      phase = "R9";
      while (!(conv_strobe && settled)) @(negedge clk);
      in_step = 1'b1;
      @(negedge clk); in_step = 1'b0;
      while (!settled && strobes < 200) begin
        if (conv_strobe) strobes++;
        @(negedge clk);
      end
      chk_int("R9", strobes, NPART);
    end

    phase = "R8";
    while (!data_ready) @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk); sync_req = 1'b0;
    chk("R3", filt_restart, 1'b1);
    chk("R8", settled, 1'b0);
    repeat (100) @(negedge clk);

    begin
      int gap = 0;
      phase = "R1";
      osr_sel = 3'd7;
      @(negedge clk);
      while (!conv_strobe) @(negedge clk);
      @(negedge clk);
      gap = 1;
      while (!conv_strobe && gap < 10000) begin
        @(negedge clk);
        gap++;
      end
      chk_int("R1", gap, 8192);
    end

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule